// File: doc/BRIEF.md
# Segmented Bus Packet Segmenter

This block takes packets one byte per cycle, each with a channel number, start and end markers and an error flag. It packs them onto a wide local bus made of several 128-bit segments. Each segment has its own enable, start, end, error, empty-count and channel fields. A packet always begins at the top byte lane of a segment. Its bytes fill that segment from the most significant lane downward. When the segment is full, the packet continues in the next segment.

Packets are handled one after another, with no interleaving. Several short packets can share one bus word: a new packet takes the next free segment after the segment where the previous packet ended. A bus word is emitted when its last segment closes. A partly filled word is also emitted on any cycle in which no byte is taken, as long as no packet is still open. A ready input from the bus side stalls the byte input. Words that are already staged are still emitted while the input is stalled.

Top module: `segpk_segmenter`

## Requirements
- R1: Within a segment, the k-th byte of that segment (k = 0 for the first) appears on bits [127-8k : 120-8k] of the segment. Segment i occupies bits [128i+127 : 128i] of `seg_data`.
- R2: A packet's first byte goes to lane 0 of the lowest segment after the segment that carries the previous packet's end. `seg_sop` is high only on the first segment of a packet.
- R3: Every enabled segment whose `seg_eop` is low holds 16 valid bytes. When such a segment is followed by an enabled segment of the same packet, that next segment has `seg_sop` low and carries the same channel, taken from the packet's first byte.
- R4: On a packet's end segment, `seg_eop` is 1 and `seg_mty` equals 16 minus the number of bytes in that segment. The unused low-order lanes read as zero. On segments that are not end segments, `seg_mty` and `seg_err` are 0.
- R5: `in_err` is reported as `seg_err` of the end segment only when it arrives together with `in_eop`. An `in_err` on any other byte has no effect.
- R6: `seg_ena` is always a contiguous run of ones starting at segment 0 (segment 0 is bit 0).
- R7: When a byte closes the highest segment, the full word appears on the outputs right after that same clock edge.
- R8: On an edge at which no byte is taken, at least one segment is closed and no packet is open, the staged segments appear on the outputs right after that edge. While a packet is open, nothing is emitted until the highest segment closes or the packet ends.
- R9: `in_ready` equals `bus_rdy` combinationally, and no byte is taken while it is low. Staged words are still emitted during a stall under the rule of R8.
- R10: A byte that arrives with no packet open and `in_sop` low is discarded. An `in_sop` that arrives while a packet is open is ignored, and the byte continues that packet.
- R11: After reset, `seg_ena` is all zero and nothing is staged.
- R12: A packet that runs past the highest segment continues in segment 0 of the next word, with `seg_sop` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Byte is taken this cycle when high (follows bus_rdy) |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_err | input | 1 | Packet error, meaningful with in_eop |
| in_chan | input | CHAN_W (8) | Channel, sampled with the first byte |
| bus_rdy | input | 1 | Bus side can accept data |
| seg_ena | output | NUM_SEG (4) | Per-segment enable |
| seg_sop | output | NUM_SEG (4) | Per-segment packet start |
| seg_eop | output | NUM_SEG (4) | Per-segment packet end |
| seg_err | output | NUM_SEG (4) | Per-segment error on the end segment |
| seg_mty | output | NUM_SEG*4 (16) | Per-segment empty-lane count |
| seg_chan | output | NUM_SEG*CHAN_W (32) | Per-segment channel |
| seg_data | output | NUM_SEG*128 (512) | Segment data |

## Verification
A word that fills the highest segment is due right after the edge that takes its closing byte. A partly filled word is due one edge later: after the first edge with no byte taken and no packet open. The bench samples all outputs on the falling edge. The directed latency checks read `seg_ena` at the falling edge just before the next stimulus is driven. This pins down these one-edge and two-edge delays exactly. For the table-driven packets, a reference model steps at the same rising edges and queues each word it expects. The monitor compares every emitted word against that queue in order, so a missing, extra or early word shows up as a miscompare.

// File: rtl/segpk_pkg.sv
`timescale 1ns/1ps
package segpk_pkg;
   localparam int LANE_BITS = 8;

   // Bit offset, within one segment, of byte lane `lane` (lane 0 is the top).
   function automatic int lane_lsb(int lane, int seg_bytes);
      return (seg_bytes - 1 - lane) * LANE_BITS;
   endfunction

   // Why a staged word leaves this cycle.
   typedef enum logic [1:0] {
      FL_NONE = 2'd0,
      FL_FULL = 2'd1,
      FL_IDLE = 2'd2
   } flush_kind_e;
endpackage

// File: rtl/segpk_cursor.sv
`timescale 1ns/1ps
// Write position tracker: which segment and lane the next byte lands in,
// whether a packet is open, and when the staged word must leave.
module segpk_cursor #(
   parameter int NUM_SEG   = 4,
   parameter int SEG_BYTES = 16,
   localparam int SEG_W    = $clog2(NUM_SEG),
   localparam int CNT_W    = SEG_W + 1,
   localparam int LANE_W   = $clog2(SEG_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              in_sop,
   input  logic              in_eop,
   output logic              take,
   output logic              start,
   output logic              close,
   output logic [SEG_W-1:0]  wr_seg,
   output logic [LANE_W-1:0] wr_lane,
   output logic              flush,
   output logic [CNT_W-1:0]  fill_cnt
);
   import segpk_pkg::*;

   logic [CNT_W-1:0]  closed_q, closed_nxt;
   logic [LANE_W-1:0] lane_q;
   logic              open_q;
   logic              last_lane;
   flush_kind_e       kind;

   assign take       = acc & (open_q | in_sop);
   assign start      = take & ~open_q;
   assign last_lane  = (lane_q == LANE_W'(SEG_BYTES - 1));
   assign close      = take & (in_eop | last_lane);
   assign closed_nxt = closed_q + CNT_W'(close);

   always_comb begin
      if (closed_nxt == CNT_W'(NUM_SEG))
         kind = FL_FULL;
      else if (!take && (closed_q != '0) && !open_q)
         kind = FL_IDLE;
      else
         kind = FL_NONE;
   end

   assign flush    = (kind != FL_NONE);
   assign wr_seg   = closed_q[SEG_W-1:0];
   assign wr_lane  = lane_q;
   assign fill_cnt = closed_nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         closed_q <= '0;
         lane_q   <= '0;
         open_q   <= 1'b0;
      end else begin
         closed_q <= flush ? '0 : closed_nxt;
         if (close)
            lane_q <= '0;
         else if (take)
            lane_q <= lane_q + 1'b1;
         if (take && in_eop)
            open_q <= 1'b0;
         else if (start)
            open_q <= 1'b1;
      end
   end
endmodule

// File: rtl/segpk_stage.sv
`timescale 1ns/1ps
// Staging word: one register set per segment, written a byte at a time.
// Exposes the contents as they will be after this cycle's write.
module segpk_stage #(
   parameter int NUM_SEG   = 4,
   parameter int SEG_BYTES = 16,
   parameter int CHAN_W    = 8,
   localparam int SEG_BITS = SEG_BYTES * 8,
   localparam int SEG_W    = $clog2(NUM_SEG),
   localparam int LANE_W   = $clog2(SEG_BYTES),
   localparam int MTY_W    = LANE_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         take,
   input  logic                         start,
   input  logic                         close,
   input  logic                         last,
   input  logic                         err_in,
   input  logic [7:0]                   byte_in,
   input  logic [CHAN_W-1:0]            chan_in,
   input  logic [SEG_W-1:0]             wr_seg,
   input  logic [LANE_W-1:0]            wr_lane,
   input  logic                         flush,
   output logic [NUM_SEG*SEG_BITS-1:0]  nxt_data,
   output logic [NUM_SEG-1:0]           nxt_sop,
   output logic [NUM_SEG-1:0]           nxt_eop,
   output logic [NUM_SEG-1:0]           nxt_err,
   output logic [NUM_SEG*MTY_W-1:0]     nxt_mty,
   output logic [NUM_SEG*CHAN_W-1:0]    nxt_chan
);
   logic [NUM_SEG*SEG_BITS-1:0] data_q;
   logic [NUM_SEG-1:0]          sop_q, eop_q, err_q;
   logic [NUM_SEG*MTY_W-1:0]    mty_q;
   logic [NUM_SEG*CHAN_W-1:0]   chan_q;
   logic [CHAN_W-1:0]           pkt_chan_q;
   logic [CHAN_W-1:0]           cur_chan;

   assign cur_chan = start ? chan_in : pkt_chan_q;

   for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
      logic sel, first, end_here;
      assign sel      = take && (wr_seg == SEG_W'(g));
      assign first    = sel && (wr_lane == '0);
      assign end_here = sel && close && last;

      for (genvar l = 0; l < SEG_BYTES; l++) begin : g_lane
         localparam int LSB = g * SEG_BITS + segpk_pkg::lane_lsb(l, SEG_BYTES);
         assign nxt_data[LSB +: 8] = (sel && (wr_lane == LANE_W'(l))) ? byte_in
                                                                    : data_q[LSB +: 8];
      end

      assign nxt_sop[g] = sop_q[g] | (sel & start);
      assign nxt_eop[g] = eop_q[g] | end_here;
      assign nxt_err[g] = end_here ? err_in : err_q[g];
      assign nxt_mty[g*MTY_W +: MTY_W] = end_here ? (MTY_W'(SEG_BYTES - 1) - wr_lane)
                                                  : mty_q[g*MTY_W +: MTY_W];
      assign nxt_chan[g*CHAN_W +: CHAN_W] = first ? cur_chan
                                                  : chan_q[g*CHAN_W +: CHAN_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         data_q <= '0;
         sop_q  <= '0;
         eop_q  <= '0;
         err_q  <= '0;
         mty_q  <= '0;
         chan_q <= '0;
      end else begin
         data_q <= nxt_data;
         sop_q  <= nxt_sop;
         eop_q  <= nxt_eop;
         err_q  <= nxt_err;
         mty_q  <= nxt_mty;
         chan_q <= nxt_chan;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         pkt_chan_q <= '0;
      else if (start)
         pkt_chan_q <= chan_in;
   end
endmodule

// File: rtl/segpk_outreg.sv
`timescale 1ns/1ps
// Output register: loads the staged word on a flush and raises the enables
// of the closed segments for one cycle.
module segpk_outreg #(
   parameter int NUM_SEG  = 4,
   parameter int SEG_BITS = 128,
   parameter int MTY_W    = 4,
   parameter int CHAN_W   = 8,
   parameter int CNT_W    = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load,
   input  logic [CNT_W-1:0]             fill_cnt,
   input  logic [NUM_SEG*SEG_BITS-1:0]  nxt_data,
   input  logic [NUM_SEG-1:0]           nxt_sop,
   input  logic [NUM_SEG-1:0]           nxt_eop,
   input  logic [NUM_SEG-1:0]           nxt_err,
   input  logic [NUM_SEG*MTY_W-1:0]     nxt_mty,
   input  logic [NUM_SEG*CHAN_W-1:0]    nxt_chan,
   output logic [NUM_SEG-1:0]           seg_ena,
   output logic [NUM_SEG-1:0]           seg_sop,
   output logic [NUM_SEG-1:0]           seg_eop,
   output logic [NUM_SEG-1:0]           seg_err,
   output logic [NUM_SEG*MTY_W-1:0]     seg_mty,
   output logic [NUM_SEG*CHAN_W-1:0]    seg_chan,
   output logic [NUM_SEG*SEG_BITS-1:0]  seg_data
);
   logic [NUM_SEG-1:0] en_mask;

   for (genvar g = 0; g < NUM_SEG; g++) begin : g_mask
      assign en_mask[g] = (fill_cnt > CNT_W'(g));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg_ena  <= '0;
         seg_sop  <= '0;
         seg_eop  <= '0;
         seg_err  <= '0;
         seg_mty  <= '0;
         seg_chan <= '0;
         seg_data <= '0;
      end else begin
         seg_ena <= load ? en_mask : '0;
         if (load) begin
            seg_sop  <= nxt_sop;
            seg_eop  <= nxt_eop;
            seg_err  <= nxt_err;
            seg_mty  <= nxt_mty;
            seg_chan <= nxt_chan;
            seg_data <= nxt_data;
         end
      end
   end
endmodule

// File: rtl/segpk_segmenter.sv
`timescale 1ns/1ps
module segpk_segmenter #(
   parameter int NUM_SEG   = 4,
   parameter int SEG_BYTES = 16,
   parameter int CHAN_W    = 8
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   in_valid,
   output logic                                   in_ready,
   input  logic [7:0]                             in_data,
   input  logic                                   in_sop,
   input  logic                                   in_eop,
   input  logic                                   in_err,
   input  logic [CHAN_W-1:0]                      in_chan,
   input  logic                                   bus_rdy,
   output logic [NUM_SEG-1:0]                     seg_ena,
   output logic [NUM_SEG-1:0]                     seg_sop,
   output logic [NUM_SEG-1:0]                     seg_eop,
   output logic [NUM_SEG-1:0]                     seg_err,
   output logic [NUM_SEG*$clog2(SEG_BYTES)-1:0]   seg_mty,
   output logic [NUM_SEG*CHAN_W-1:0]              seg_chan,
   output logic [NUM_SEG*SEG_BYTES*8-1:0]         seg_data
);
   localparam int SEG_BITS = SEG_BYTES * 8;
   localparam int SEG_W    = $clog2(NUM_SEG);
   localparam int CNT_W    = SEG_W + 1;
   localparam int LANE_W   = $clog2(SEG_BYTES);
   localparam int MTY_W    = LANE_W;

   if (NUM_SEG < 2 || (NUM_SEG & (NUM_SEG - 1)) != 0) begin : g_bad_seg
      $error("NUM_SEG must be a power of two of at least 2");
   end
   if (SEG_BYTES < 2 || (SEG_BYTES & (SEG_BYTES - 1)) != 0) begin : g_bad_bytes
      $error("SEG_BYTES must be a power of two of at least 2");
   end
   if (CHAN_W < 1) begin : g_bad_chan
      $error("CHAN_W must be at least 1");
   end

   logic                        acc, take, start, close, flush;
   logic [SEG_W-1:0]            wr_seg;
   logic [LANE_W-1:0]           wr_lane;
   logic [CNT_W-1:0]            fill_cnt;
   logic [NUM_SEG*SEG_BITS-1:0] nxt_data;
   logic [NUM_SEG-1:0]          nxt_sop, nxt_eop, nxt_err;
   logic [NUM_SEG*MTY_W-1:0]    nxt_mty;
   logic [NUM_SEG*CHAN_W-1:0]   nxt_chan;

   assign in_ready = bus_rdy;
   assign acc      = in_valid & bus_rdy;

   segpk_cursor #(.NUM_SEG(NUM_SEG), .SEG_BYTES(SEG_BYTES)) u_cursor (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (acc),
      .in_sop   (in_sop),
      .in_eop   (in_eop),
      .take     (take),
      .start    (start),
      .close    (close),
      .wr_seg   (wr_seg),
      .wr_lane  (wr_lane),
      .flush    (flush),
      .fill_cnt (fill_cnt)
   );

   segpk_stage #(.NUM_SEG(NUM_SEG), .SEG_BYTES(SEG_BYTES), .CHAN_W(CHAN_W)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .start    (start),
      .close    (close),
      .last     (in_eop),
      .err_in   (in_err),
      .byte_in  (in_data),
      .chan_in  (in_chan),
      .wr_seg   (wr_seg),
      .wr_lane  (wr_lane),
      .flush    (flush),
      .nxt_data (nxt_data),
      .nxt_sop  (nxt_sop),
      .nxt_eop  (nxt_eop),
      .nxt_err  (nxt_err),
      .nxt_mty  (nxt_mty),
      .nxt_chan (nxt_chan)
   );

   segpk_outreg #(
      .NUM_SEG(NUM_SEG), .SEG_BITS(SEG_BITS), .MTY_W(MTY_W),
      .CHAN_W(CHAN_W), .CNT_W(CNT_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (flush),
      .fill_cnt (fill_cnt),
      .nxt_data (nxt_data),
      .nxt_sop  (nxt_sop),
      .nxt_eop  (nxt_eop),
      .nxt_err  (nxt_err),
      .nxt_mty  (nxt_mty),
      .nxt_chan (nxt_chan),
      .seg_ena  (seg_ena),
      .seg_sop  (seg_sop),
      .seg_eop  (seg_eop),
      .seg_err  (seg_err),
      .seg_mty  (seg_mty),
      .seg_chan (seg_chan),
      .seg_data (seg_data)
   );
endmodule

// File: rtl/segpk_chk.sv
`timescale 1ns/1ps
module segpk_chk #(
   parameter int NUM_SEG   = 4,
   parameter int SEG_BYTES = 16,
   parameter int CHAN_W    = 8,
   localparam int SEG_BITS = SEG_BYTES * 8,
   localparam int MTY_W    = $clog2(SEG_BYTES)
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [NUM_SEG-1:0]           seg_ena,
   input logic [NUM_SEG-1:0]           seg_sop,
   input logic [NUM_SEG-1:0]           seg_eop,
   input logic [NUM_SEG-1:0]           seg_err,
   input logic [NUM_SEG*MTY_W-1:0]     seg_mty,
   input logic [NUM_SEG*CHAN_W-1:0]    seg_chan,
   input logic [NUM_SEG*SEG_BITS-1:0]  seg_data
);
   function automatic logic [SEG_BITS-1:0] low_mask(logic [MTY_W-1:0] m);
      return ~({SEG_BITS{1'b1}} << {m, 3'b000});
   endfunction

   AST_ENA_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
      ((seg_ena & (seg_ena + NUM_SEG'(1))) == '0)); // R6

   for (genvar g = 0; g < NUM_SEG; g++) begin : g_a
      AST_MID_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
         (seg_ena[g] && !seg_eop[g]) |->
            (seg_mty[g*MTY_W +: MTY_W] == '0) && !seg_err[g]); // R4

      AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (seg_ena[g] && seg_eop[g]) |->
            ((seg_data[g*SEG_BITS +: SEG_BITS] & low_mask(seg_mty[g*MTY_W +: MTY_W])) == '0)); // R4

      if (g > 0) begin : g_prev
         AST_SOP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
            (seg_ena[g] && seg_sop[g]) |-> seg_eop[g-1]); // R2
      end

      if (g < NUM_SEG - 1) begin : g_next
         AST_CHAN_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
            (seg_ena[g+1] && !seg_eop[g]) |->
               (!seg_sop[g+1] &&
                seg_chan[(g+1)*CHAN_W +: CHAN_W] == seg_chan[g*CHAN_W +: CHAN_W])); // R3
      end
   end
endmodule

bind segpk_segmenter segpk_chk #(
   .NUM_SEG(NUM_SEG), .SEG_BYTES(SEG_BYTES), .CHAN_W(CHAN_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .seg_ena  (seg_ena),
   .seg_sop  (seg_sop),
   .seg_eop  (seg_eop),
   .seg_err  (seg_err),
   .seg_mty  (seg_mty),
   .seg_chan (seg_chan),
   .seg_data (seg_data)
);

// File: tb/segpk_segmenter_tb.sv
`timescale 1ns/1ps
module segpk_segmenter_tb;
   localparam int NS    = 4;
   localparam int SB    = 16;
   localparam int CW    = 8;
   localparam int SBITS = SB * 8;
   localparam int MW    = $clog2(SB);
   localparam int DW    = NS * SBITS;
   localparam int CTLW  = 4 * NS + NS * MW + NS * CW;

   // Packet table: {chan[31:24], length[23:16], err[8], idle gap[7:0]}
   localparam logic [31:0] PKT_TAB [12] = '{
      32'h11_10_00_00, 32'h12_01_00_00, 32'h13_11_01_00, 32'h14_40_00_02,
      32'h15_05_00_00, 32'h16_21_00_01, 32'h17_0F_01_00, 32'h18_30_00_03,
      32'h19_02_00_00, 32'h1A_50_00_00, 32'h1B_10_00_00, 32'h1C_03_01_04
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0;
   logic [7:0]        in_data = '0;
   logic [CW-1:0]     in_chan = '0;
   logic              bus_rdy = 1'b1;
   logic              in_ready;
   logic [NS-1:0]     seg_ena, seg_sop, seg_eop, seg_err;
   logic [NS*MW-1:0]  seg_mty;
   logic [NS*CW-1:0]  seg_chan;
   logic [DW-1:0]     seg_data;

   always #2.5 clk = ~clk;

   segpk_segmenter #(.NUM_SEG(NS), .SEG_BYTES(SB), .CHAN_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err),
      .in_chan(in_chan), .bus_rdy(bus_rdy), .seg_ena(seg_ena), .seg_sop(seg_sop),
      .seg_eop(seg_eop), .seg_err(seg_err), .seg_mty(seg_mty), .seg_chan(seg_chan),
      .seg_data(seg_data)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;
   logic [NS-1:0] obs_ena;
   logic          obs_rdy;

   task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   logic [DW-1:0]    m_data = '0;
   logic [NS-1:0]    m_sop = '0, m_eop = '0, m_err = '0;
   logic [NS*MW-1:0] m_mty = '0;
   logic [NS*CW-1:0] m_chan = '0;
   logic [CW-1:0]    m_pch = '0;
   int               m_closed = 0, m_lane = 0;
   bit               m_open = 0;
   logic [DW-1:0]    q_data [$];
   logic [CTLW-1:0]  q_ctl  [$];

   task automatic model_step(bit acc, logic [7:0] b, bit s, bit e, bit er, logic [CW-1:0] ch);
      bit tk;
      int sg, ln;
      logic [NS-1:0] ena;
      tk = acc && (m_open || s);
      if (tk) begin
         sg = m_closed;
         ln = m_lane;
         if (!m_open) begin
            m_pch   = ch;
            m_sop[sg] = 1'b1;
            m_open  = 1;
         end
         m_data[sg*SBITS + (SB-1-ln)*8 +: 8] = b;
         if (ln == 0) m_chan[sg*CW +: CW] = m_pch;
         if (e || ln == SB-1) begin
            if (e) begin
               m_eop[sg] = 1'b1;
               m_err[sg] = er;
               m_mty[sg*MW +: MW] = MW'(SB-1-ln);
               m_open = 0;
            end
            m_closed++;
            m_lane = 0;
         end else begin
            m_lane++;
         end
      end
      if (m_closed == NS || (!tk && m_closed > 0 && !m_open)) begin
         ena = NS'((1 << m_closed) - 1);
         q_data.push_back(m_data);
         q_ctl.push_back({ena, m_sop, m_eop, m_err, m_mty, m_chan});
         m_data = '0; m_sop = '0; m_eop = '0; m_err = '0; m_mty = '0; m_chan = '0;
         m_closed = 0;
      end
   endtask

   // ---------------- monitor ----------------
   always @(negedge clk) begin
      if (rst_n && seg_ena != '0) begin
         if (q_ctl.size() == 0) begin
            chk(1'b0, "R8 unexpected word", DW'(seg_ena), '0);
         end else begin
            logic [DW-1:0]   ed;
            logic [CTLW-1:0] ec;
            ed = q_data.pop_front();
            ec = q_ctl.pop_front();
            chk(seg_data == ed, "R1 data lanes", seg_data, ed);
            chk({seg_ena, seg_sop, seg_eop, seg_err, seg_mty, seg_chan} == ec,
                "R2 R3 R4 R6 segment control",
                DW'({seg_ena, seg_sop, seg_eop, seg_err, seg_mty, seg_chan}), DW'(ec));
         end
      end
   end

   // ---------------- drivers ----------------
   task automatic drive(bit v, logic [7:0] b, bit s, bit e, bit er, logic [CW-1:0] ch);
      @(negedge clk);
      obs_ena  = seg_ena;
      obs_rdy  = in_ready;
      in_valid = v; in_data = b; in_sop = s; in_eop = e; in_err = er; in_chan = ch;
      @(posedge clk);
      #1;
      model_step(v && bus_rdy, b, s, e, er, ch);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) drive(0, 8'h00, 0, 0, 0, '0);
   endtask

   function automatic logic [7:0] pat(int id, int b);
      return 8'((id * 37) + b + 1);
   endfunction

   task automatic send_pkt(int id, int len, bit er, logic [CW-1:0] ch);
      for (int b = 0; b < len; b++)
         drive(1, pat(id, b), b == 0, b == len-1, er && (b == len-1), ch);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(seg_ena == '0, "R11 reset enables", DW'(seg_ena), '0);
      chk(in_ready == 1'b1, "R9 ready follows bus_rdy high", DW'(in_ready), 1);
      bus_rdy = 1'b0;
      #1;
      chk(in_ready == 1'b0, "R9 ready follows bus_rdy low", DW'(in_ready), 0);
      bus_rdy = 1'b1;

      // Table walk: mixed lengths cover packing (R2), full segments (R3),
      // end counts (R4), error with end (R5), word overflow (R12).
      for (int i = 0; i < 12; i++) begin
         send_pkt(i, int'(PKT_TAB[i][23:16]), PKT_TAB[i][8], PKT_TAB[i][31:24]);
         idle(int'(PKT_TAB[i][7:0]));
      end
      idle(4);

      // R8: partial word due one edge after the first empty edge
      send_pkt(20, 16, 0, 8'h21);
      drive(0, 0, 0, 0, 0, '0);
      chk(obs_ena == '0, "R8 no word before idle edge", DW'(obs_ena), '0);
      drive(0, 0, 0, 0, 0, '0);
      chk(obs_ena == 4'b0001, "R8 partial word timing", DW'(obs_ena), 4'b0001);

      // R7: full word right after the closing edge
      for (int p = 0; p < 4; p++) send_pkt(21 + p, 16, 0, 8'h30 + 8'(p));
      drive(0, 0, 0, 0, 0, '0);
      chk(obs_ena == 4'b1111, "R7 full word timing", DW'(obs_ena), 4'b1111);
      idle(1);

      // R8: nothing emitted while a packet is open
      for (int b = 0; b < 17; b++) drive(1, pat(30, b), b == 0, 0, 0, 8'h44);
      for (int k = 0; k < 3; k++) begin
         drive(0, 0, 0, 0, 0, '0);
         chk(obs_ena == '0, "R8 held while packet open", DW'(obs_ena), '0);
      end
      for (int b = 17; b < 20; b++) drive(1, pat(30, b), 0, b == 19, 0, 8'h44);
      drive(0, 0, 0, 0, 0, '0);
      drive(0, 0, 0, 0, 0, '0);
      chk(obs_ena == 4'b0011, "R8 open packet released at end", DW'(obs_ena), 4'b0011);

      // R10: bytes with no packet open and no start are dropped
      for (int b = 0; b < 3; b++) drive(1, 8'hEE, 0, 0, 0, 8'h55);
      drive(0, 0, 0, 0, 0, '0);
      drive(0, 0, 0, 0, 0, '0);
      chk(obs_ena == '0, "R10 stray bytes dropped", DW'(obs_ena), '0);
      // R10 start inside open packet ignored; R5 error on middle byte ignored
      drive(1, 8'hA0, 1, 0, 0, 8'h66);
      drive(1, 8'hA1, 0, 0, 1, 8'h77);
      drive(1, 8'hA2, 1, 0, 0, 8'h77);
      drive(1, 8'hA3, 0, 0, 0, 8'h77);
      drive(1, 8'hA4, 0, 0, 0, 8'h77);
      drive(1, 8'hA5, 0, 1, 0, 8'h77);
      idle(2);

      // R9: stall takes no bytes but still emits staged data
      send_pkt(40, 10, 1, 8'h88);
      bus_rdy = 1'b0;
      drive(1, pat(41, 0), 1, 0, 0, 8'h99);
      chk(obs_rdy == 1'b0, "R9 ready low during stall", DW'(obs_rdy), 0);
      drive(1, pat(41, 0), 1, 0, 0, 8'h99);
      chk(obs_ena == 4'b0001, "R9 staged word leaves during stall", DW'(obs_ena), 4'b0001);
      drive(1, pat(41, 0), 1, 0, 0, 8'h99);
      chk(obs_ena == '0, "R9 no byte taken while stalled", DW'(obs_ena), '0);
      bus_rdy = 1'b1;
      send_pkt(41, 5, 0, 8'h99);
      idle(4);

      chk(q_ctl.size() == 0, "R8 all expected words emitted", DW'(q_ctl.size()), '0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule